// File: doc/BRIEF.md
# I2C Register Read Target with Group Checksum

This block is the serial-bus face of a sensor register file. A controller first writes a pointer byte. Bits 6:0 of that byte choose the starting register, and bit 7 asks for a new conversion. After a repeated START and the target's address with the read bit set, the block streams registers one after another. The pointer advances after each acknowledged byte.

When the checksum option is on, the block inserts a CRC-8 byte after every four register bytes. The CRC covers those four bytes. The controller can then verify each group as it arrives.

The bus pins are open-drain in style. Each line has a separate input, and SDA has an output-enable that pulls the line low when set. Register data comes from a synchronous read port: data appears one clock after the address. A request for a conversion appears as a one-clock pulse to the converter.

The controller runs on a fast system clock. SCL and SDA pass through synchronisers, and edge and START/STOP detectors follow them.

The controller has ten states:
- `S_IDLE`: bus free.
- `S_ADDR` and `S_PTR`: shifting in eight bits.
- `S_ADDR_END` and `S_PTR_END`: the eighth bit has been taken, and the state waits for SCL to fall.
- `S_ADDR_ACK` and `S_PTR_ACK`: holding SDA low for the ninth clock.
- `S_TX`: driving a byte.
- `S_TX_ACK`: reading the controller's acknowledge.
- `S_WAIT`: bus ignored until START or STOP.

Its transitions are:
- START goes to `S_ADDR` from any state.
- STOP goes to `S_IDLE` from any state.
- `S_ADDR` goes to `S_ADDR_END` on the eighth rising edge.
- `S_ADDR_END` goes to `S_ADDR_ACK` on a falling edge if the address matches, and to `S_WAIT` if it does not.
- `S_ADDR_ACK` goes to `S_TX` on a read and to `S_PTR` on a write.
- `S_PTR` goes to `S_PTR_END`.
- `S_PTR_END` goes to `S_PTR_ACK`.
- `S_PTR_ACK` goes to `S_WAIT`. The pointer is loaded and the trigger is issued on this step.
- `S_TX` goes to `S_TX_ACK` after eight bits.
- `S_TX_ACK` goes to `S_TX` on ACK and to `S_WAIT` on NACK.

Top module: `i2c_rdt_target`

## Requirements
- R1: During and right after reset, `sda_oe` and `conv_pulse` are 0.
- R2: A first byte whose upper seven bits equal `TGT_ADDR` is acknowledged by SDA low in the ninth clock. This holds for both values of bit 0, where 0 means write and 1 means read.
- R3: A first byte with any other address gets no acknowledge. After that the block drives SDA for nothing (later bytes read as 0xFF and are not acknowledged) until the next START.
- R4: In the byte after a write address, bits 6:0 load the register pointer. The byte is acknowledged. The first byte of a following read is the register at that pointer.
- R5: If bit 7 of the pointer byte is 1, `conv_pulse` is high for exactly one clock once that byte's acknowledge ends. If bit 7 is 0, no pulse is issued.
- R6: Every register byte acknowledged by the controller advances the pointer by one, and the pointer wraps from 0x7F to 0x00.
- R7: With checksum enabled, a CRC byte follows every four register bytes. The CRC uses polynomial 0x07, initial value 0xFF, MSB first, with no final XOR. It restarts for each group, and the CRC byte does not advance the pointer.
- R8: `crc_en` is sampled at every START or repeated START. Changing it later in the transaction has no effect.
- R9: A NACK from the controller ends the read. SDA is released and stays released until START or STOP.
- R10: `sda_oe` changes only while the synchronised SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | SCL line level |
| sda_i | input | 1 | SDA line level |
| sda_oe | output | 1 | 1 pulls SDA low |
| crc_en | input | 1 | Insert a CRC byte after each group of four |
| rd_addr | output | 7 | Register read address (current pointer) |
| rd_data | input | 8 | Register data, valid one clock after `rd_addr` |
| conv_pulse | output | 1 | One-clock conversion request |

## Verification
The bench crosses the pointer wrap inside a checksum group. A design that counted the CRC byte as a register, or failed to wrap, would return the wrong register after the checksum.

It switches `crc_en` after the repeated START. A design that read the input live would insert an unexpected CRC byte.

It sends a foreign address and then keeps clocking. A target that did not go quiet would acknowledge or drive read data. It also clocks a byte after a NACK, where any SDA drive shows up as a non-0xFF value.

Trigger pulses are counted and their width is checked. This catches a pulse that repeats, lasts more than one clock or fires for a clear bit 7.

// File: rtl/i2c_rdt_pkg.sv
package i2c_rdt_pkg;

    typedef enum logic [3:0] {
        S_IDLE,
        S_ADDR,
        S_ADDR_END,
        S_ADDR_ACK,
        S_PTR,
        S_PTR_END,
        S_PTR_ACK,
        S_TX,
        S_TX_ACK,
        S_WAIT
    } tgt_state_e;

    // One byte through an MSB-first CRC-8 register.
    function automatic logic [7:0] crc8_step(input logic [7:0] c,
                                             input logic [7:0] d,
                                             input logic [7:0] poly);
        logic [7:0] r;
        logic       fb;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            fb = r[7] ^ d[i];
            r  = {r[6:0], 1'b0};
            if (fb) r = r ^ poly;
        end
        return r;
    endfunction

endpackage

// File: rtl/i2c_rdt_line_sync.sv
module i2c_rdt_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        logic q_scl;
        logic q_sda;
        if (i == 0) begin : g_first
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_scl <= 1'b1;
                    q_sda <= 1'b1;
                end else begin
                    q_scl <= scl_i;
                    q_sda <= sda_i;
                end
            end
        end else begin : g_next
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    q_scl <= 1'b1;
                    q_sda <= 1'b1;
                end else begin
                    q_scl <= g_stage[i-1].q_scl;
                    q_sda <= g_stage[i-1].q_sda;
                end
            end
        end
    end

    assign scl_s = g_stage[STAGES-1].q_scl;
    assign sda_s = g_stage[STAGES-1].q_sda;

    logic scl_p;
    logic sda_p;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_p <= 1'b1;
            sda_p <= 1'b1;
        end else begin
            scl_p <= scl_s;
            sda_p <= sda_s;
        end
    end

    assign scl_rise  =  scl_s & ~scl_p;
    assign scl_fall  = ~scl_s &  scl_p;
    assign start_det =  scl_s &  scl_p &  sda_p & ~sda_s;
    assign stop_det  =  scl_s &  scl_p & ~sda_p &  sda_s;

endmodule

// File: rtl/i2c_rdt_crc8.sv
module i2c_rdt_crc8
    import i2c_rdt_pkg::*;
#(
    parameter logic [7:0] POLY = 8'h07,
    parameter logic [7:0] INIT = 8'hFF
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       clear,
    input  logic       update,
    input  logic [7:0] din,
    output logic [7:0] crc
);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      crc <= INIT;
        else if (clear)  crc <= INIT;
        else if (update) crc <= crc8_step(crc, din, POLY);
    end

endmodule

// File: rtl/i2c_rdt_txsel.sv
module i2c_rdt_txsel #(
    parameter int PTR_W = 7,
    parameter int GROUP = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             restart,
    input  logic             crc_on,
    input  logic             ptr_load,
    input  logic [PTR_W-1:0] ptr_val,
    input  logic             advance,
    input  logic [7:0]       rd_data,
    output logic [PTR_W-1:0] rd_addr,
    output logic [7:0]       tx_byte
);

    localparam int GW = $clog2(GROUP + 1);
    localparam logic [GW-1:0] GROUP_END = GW'(GROUP);

    logic [PTR_W-1:0] ptr;
    logic [GW-1:0]    grp;
    logic [7:0]       crc;
    logic             crc_slot;

    assign crc_slot = crc_on && (grp == GROUP_END);
    assign tx_byte  = crc_slot ? crc : rd_data;
    assign rd_addr  = ptr;

    i2c_rdt_crc8 #(.POLY(8'h07), .INIT(8'hFF)) u_crc (
        .clk    (clk),
        .rst_n  (rst_n),
        .clear  (restart | (advance & crc_slot)),
        .update (advance & ~crc_slot),
        .din    (rd_data),
        .crc    (crc)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr <= '0;
            grp <= '0;
        end else begin
            if (restart) begin
                grp <= '0;
            end else if (advance) begin
                if (crc_slot)    grp <= '0;
                else if (crc_on) grp <= grp + 1'b1;
            end
            if (ptr_load)                  ptr <= ptr_val;
            else if (advance && !crc_slot) ptr <= ptr + 1'b1;
        end
    end

    // R6: a register byte advances the pointer by one, wrapping at the top
    a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && !crc_slot && !ptr_load) |=> (ptr == $past(ptr) + 1'b1));

    // R7: the group counter never passes the group size
    a_r7_group_bound: assert property (@(posedge clk) disable iff (!rst_n)
        grp <= GROUP_END);

    // R7: the checksum byte neither moves the pointer and starts a new group
    a_r7_slot_restarts: assert property (@(posedge clk) disable iff (!rst_n)
        (advance && crc_slot && !restart) |=> (grp == '0 && $stable(ptr)));

endmodule

// File: rtl/i2c_rdt_target.sv
module i2c_rdt_target
    import i2c_rdt_pkg::*;
#(
    parameter logic [6:0] TGT_ADDR    = 7'h35,
    parameter int         SYNC_STAGES = 2,
    parameter int         CRC_GROUP   = 4
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_i,
    input  logic       sda_i,
    output logic       sda_oe,
    input  logic       crc_en,
    output logic [6:0] rd_addr,
    input  logic [7:0] rd_data,
    output logic       conv_pulse
);

    localparam int BYTE_W = 8;
    localparam int PTR_W  = BYTE_W - 1;
    localparam logic [2:0] LAST_BIT = 3'(BYTE_W - 1);

    logic scl_s, sda_s, scl_rise, scl_fall, start_det, stop_det;

    i2c_rdt_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk       (clk),
        .rst_n     (rst_n),
        .scl_i     (scl_i),
        .sda_i     (sda_i),
        .scl_s     (scl_s),
        .sda_s     (sda_s),
        .scl_rise  (scl_rise),
        .scl_fall  (scl_fall),
        .start_det (start_det),
        .stop_det  (stop_det)
    );

    tgt_state_e      state, state_n;
    logic [2:0]      cnt;
    logic [7:0]      sh;
    logic            is_read;
    logic            crc_on;
    logic            ack_seen;
    logic            bus_ev;
    logic            addr_hit;
    logic            advance;
    logic            ptr_load;
    logic [7:0]      tx_byte;

    assign bus_ev   = start_det | stop_det;
    assign addr_hit = (sh[7:1] == TGT_ADDR);

    i2c_rdt_txsel #(.PTR_W(PTR_W), .GROUP(CRC_GROUP)) u_txsel (
        .clk      (clk),
        .rst_n    (rst_n),
        .restart  (start_det),
        .crc_on   (crc_on),
        .ptr_load (ptr_load),
        .ptr_val  (sh[PTR_W-1:0]),
        .advance  (advance),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .tx_byte  (tx_byte)
    );

    // Next-state logic
    always_comb begin
        state_n = state;
        if (start_det) begin
            state_n = S_ADDR;
        end else if (stop_det) begin
            state_n = S_IDLE;
        end else begin
            unique case (state)
                S_IDLE:     state_n = S_IDLE;
                S_ADDR:     if (scl_rise && cnt == LAST_BIT) state_n = S_ADDR_END;
                S_ADDR_END: if (scl_fall) state_n = addr_hit ? S_ADDR_ACK : S_WAIT;
                S_ADDR_ACK: if (scl_fall) state_n = is_read ? S_TX : S_PTR;
                S_PTR:      if (scl_rise && cnt == LAST_BIT) state_n = S_PTR_END;
                S_PTR_END:  if (scl_fall) state_n = S_PTR_ACK;
                S_PTR_ACK:  if (scl_fall) state_n = S_WAIT;
                S_TX:       if (scl_fall && cnt == LAST_BIT) state_n = S_TX_ACK;
                S_TX_ACK:   if (scl_fall) state_n = ack_seen ? S_TX : S_WAIT;
                S_WAIT:     state_n = S_WAIT;
                default:    state_n = S_IDLE;
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= S_IDLE;
        else        state <= state_n;
    end

    // Datapath: shifter, bit counter, direction, sampled options
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt      <= '0;
            sh       <= '0;
            is_read  <= 1'b0;
            crc_on   <= 1'b0;
            ack_seen <= 1'b0;
        end else if (start_det) begin
            cnt    <= '0;
            crc_on <= crc_en;
        end else if (!stop_det) begin
            unique case (state)
                S_ADDR, S_PTR: begin
                    if (scl_rise) begin
                        sh  <= {sh[6:0], sda_s};
                        cnt <= cnt + 1'b1;
                    end
                end
                S_ADDR_END: begin
                    if (scl_fall && addr_hit) is_read <= sh[0];
                end
                S_ADDR_ACK: begin
                    if (scl_fall) begin
                        cnt <= '0;
                        if (is_read) sh <= tx_byte;
                    end
                end
                S_TX: begin
                    if (scl_fall) begin
                        sh  <= {sh[6:0], 1'b0};
                        cnt <= cnt + 1'b1;
                    end
                end
                S_TX_ACK: begin
                    if (scl_rise) ack_seen <= ~sda_s;
                    if (scl_fall && ack_seen) begin
                        sh  <= tx_byte;
                        cnt <= '0;
                    end
                end
                default: ;
            endcase
        end
    end

    // Outputs and strobes
    always_comb begin
        sda_oe   = 1'b0;
        advance  = 1'b0;
        ptr_load = 1'b0;
        unique case (state)
            S_ADDR_ACK: begin
                sda_oe  = 1'b1;
                advance = scl_fall && is_read && !bus_ev;
            end
            S_PTR_ACK: begin
                sda_oe   = 1'b1;
                ptr_load = scl_fall && !bus_ev;
            end
            S_TX:     sda_oe  = ~sh[7];
            S_TX_ACK: advance = scl_fall && ack_seen && !bus_ev;
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) conv_pulse <= 1'b0;
        else        conv_pulse <= ptr_load && sh[7];
    end

    // R5: the conversion request lasts one clock
    a_r5_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        conv_pulse |=> !conv_pulse);

    // R10: SDA drive does not move while SCL is high
    a_r10_quiet_high: assert property (@(posedge clk) disable iff (!rst_n)
        (scl_s && $past(scl_s)) |-> $stable(sda_oe));

    // R9: a NACK releases SDA and parks the controller
    a_r9_nack_release: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_TX_ACK && scl_fall && !ack_seen && !bus_ev)
            |=> (!sda_oe && state == S_WAIT));

    // R3: a foreign address never leads to an acknowledge
    a_r3_no_foreign_ack: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_ADDR_END && scl_fall && !addr_hit && !bus_ev)
            |=> (state == S_WAIT && !sda_oe));

endmodule

// File: tb/i2c_rdt_target_bench.sv
module i2c_rdt_target_bench;

    localparam logic [6:0] OWN_ADDR = 7'h35;
    localparam int Q = 10;

    typedef struct packed {
        logic [6:0] ptr;
        logic       trig;
        logic [4:0] n;
        logic       cen;
    } vec_t;

    localparam vec_t VECS [4] = '{
        '{ptr: 7'h10, trig: 1'b0, n: 5'd3,  cen: 1'b0},
        '{ptr: 7'h7E, trig: 1'b1, n: 5'd4,  cen: 1'b0},
        '{ptr: 7'h20, trig: 1'b0, n: 5'd10, cen: 1'b1},
        '{ptr: 7'h7D, trig: 1'b1, n: 5'd7,  cen: 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       scl, sda_m, crc_en;
    logic       sda_oe, conv_pulse;
    logic [6:0] rd_addr;
    logic [7:0] rd_data;
    wire        sda_line = sda_m & ~sda_oe;

    int checks = 0;
    int errors = 0;
    int pulses = 0;
    int wide   = 0;
    logic prev_pulse = 1'b0;
    bit done = 1'b0;

    logic [7:0] mem [128];

    always #2 clk = ~clk;

    i2c_rdt_target #(.TGT_ADDR(OWN_ADDR)) u_i2c_rdt_target (
        .clk        (clk),
        .rst_n      (rst_n),
        .scl_i      (scl),
        .sda_i      (sda_line),
        .sda_oe     (sda_oe),
        .crc_en     (crc_en),
        .rd_addr    (rd_addr),
        .rd_data    (rd_data),
        .conv_pulse (conv_pulse)
    );

    initial begin
        for (int i = 0; i < 128; i++) mem[i] = 8'(i * 29 + 7);
    end

    always @(posedge clk) rd_data <= mem[rd_addr];

    always @(posedge clk) begin
        if (conv_pulse) pulses++;
        if (conv_pulse && prev_pulse) wide++;
        prev_pulse <= conv_pulse;
    end

    function automatic logic [7:0] ref_crc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        r = c ^ d;
        for (int i = 0; i < 8; i++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
        return r;
    endfunction

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: act=%0h exp=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic bus_start;
        sda_m = 1'b1; tick(Q);
        scl   = 1'b1; tick(Q);
        sda_m = 1'b0; tick(Q);
        scl   = 1'b0; tick(Q);
    endtask

    task automatic bus_stop;
        sda_m = 1'b0; tick(Q);
        scl   = 1'b1; tick(Q);
        sda_m = 1'b1; tick(Q);
    endtask

    task automatic wr_byte(input logic [7:0] b, output logic acked);
        for (int i = 7; i >= 0; i--) begin
            sda_m = b[i]; tick(Q);
            scl = 1'b1;   tick(2 * Q);
            scl = 1'b0;
        end
        sda_m = 1'b1; tick(Q);
        scl = 1'b1;   tick(Q);
        acked = ~sda_line;
        tick(Q);
        scl = 1'b0;   tick(Q);
    endtask

    task automatic rd_byte(input logic give_ack, output logic [7:0] b);
        b = '0;
        sda_m = 1'b1;
        for (int i = 0; i < 8; i++) begin
            tick(Q);
            scl = 1'b1; tick(Q);
            b = {b[6:0], sda_line};
            tick(Q);
            scl = 1'b0;
        end
        sda_m = ~give_ack; tick(Q);
        scl = 1'b1;        tick(2 * Q);
        scl = 1'b0;        tick(Q);
        sda_m = 1'b1;
    endtask

    // Pointer write, repeated START, read of n bytes with model comparison.
    // cen_late: value applied to crc_en right after the read address.
    task automatic run_read(input logic [6:0] ptr, input logic trig, input int n,
                            input logic cen, input logic cen_late);
        logic       a;
        logic [7:0] b, e;
        logic [6:0] p;
        int         g, p0;
        logic [7:0] c;
        crc_en = cen;
        bus_start;
        wr_byte({OWN_ADDR, 1'b0}, a); chk("R2 write address ack", a, 1);
        p0 = pulses;
        wr_byte({trig, ptr}, a);      chk("R4 pointer ack", a, 1);
        bus_start;
        wr_byte({OWN_ADDR, 1'b1}, a); chk("R2 read address ack", a, 1);
        crc_en = cen_late;
        chk("R5 trigger pulse count", pulses - p0, {31'd0, trig});
        p = ptr; g = 0; c = 8'hFF;
        for (int k = 0; k < n; k++) begin
            rd_byte(k != n - 1, b);
            if (cen && g == 4) begin
                e = c; g = 0; c = 8'hFF;
                chk("R7 checksum byte", b, e);
            end else begin
                e = mem[p]; c = ref_crc(c, e); g++; p = p + 7'd1;
                if (k == 0) chk("R4 first register", b, e);
                else        chk("R6 next register", b, e);
            end
        end
        bus_stop;
    endtask

    initial begin
        logic a;
        logic [7:0] b;
        rst_n = 1'b0; scl = 1'b1; sda_m = 1'b1; crc_en = 1'b0;
        tick(5);
        chk("R1 sda_oe in reset", sda_oe, 0);
        chk("R1 conv_pulse in reset", conv_pulse, 0);
        rst_n = 1'b1;
        tick(5);
        chk("R1 sda_oe after reset", sda_oe, 0);
        chk("R1 conv_pulse after reset", conv_pulse, 0);

        foreach (VECS[v])
            run_read(VECS[v].ptr, VECS[v].trig, int'(VECS[v].n), VECS[v].cen, VECS[v].cen);

        // R3: foreign address, then more traffic before the next START
        begin
            int p0;
            p0 = pulses;
            bus_start;
            wr_byte({7'h12, 1'b0}, a); chk("R3 foreign address not acked", a, 0);
            wr_byte(8'h85, a);         chk("R3 later byte not acked", a, 0);
            rd_byte(1'b1, b);          chk("R3 no drive after mismatch", b, 8'hFF);
            chk("R3 no trigger after mismatch", pulses - p0, 0);
            bus_stop;
        end

        // R8: crc_en raised after the repeated START has no effect
        run_read(7'h40, 1'b0, 6, 1'b0, 1'b1);
        // R8: crc_en dropped after the repeated START keeps the checksum
        run_read(7'h50, 1'b0, 5, 1'b1, 1'b0);

        // R9: NACK ends the read; a further byte is not driven
        begin
            crc_en = 1'b0;
            bus_start;
            wr_byte({OWN_ADDR, 1'b0}, a);
            wr_byte(8'h05, a);
            bus_start;
            wr_byte({OWN_ADDR, 1'b1}, a);
            rd_byte(1'b0, b);     chk("R9 byte before NACK", b, mem[5]);
            rd_byte(1'b1, b);     chk("R9 released after NACK", b, 8'hFF);
            chk("R9 sda_oe low after NACK", sda_oe, 0);
            bus_stop;
        end

        chk("R5 pulse width one clock", wide, 0);
        chk("R10 sda_oe idle at end", sda_oe, 0);

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL R1 watchdog: act=timeout exp=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule